// File: doc/BRIEF.md
# Transmit Descriptor Error-Halt Sequencer

This block steps through a circular set of transmit buffer descriptors kept in a small descriptor RAM. It holds the index of the descriptor now in use. Each time the transmit path reports that a descriptor has completed, the block either moves to the next index or, when the frame failed, stops. When a frame's last descriptor completes normally, the block writes that descriptor's completion status back through a status write port.

When a frame is aborted or ends in error, the block writes a status with a failure flag into the descriptor in use. That descriptor need not be the frame's last one. The block then halts, sets a sticky transmit-error interrupt bit and records the failing descriptor's address in an error-pointer register.

While halted, the block ignores further completion reports. Software reads the error pointer and writes a restart address into a recovery register. It then raises a clear-control input from 0 to 1. That rising edge reloads the current index from the recovery register and resumes normal sequencing.

Top module: `txh_ctrl`

## Requirements
- R1: After a synchronous reset, the current index, the error pointer and the recovery pointer are 0. The halt flag, the error interrupt bit and the status write strobe are all 0.
- R2: While running, each completion report without failure advances the current index by one on the next edge. The index wraps from NUM_BD-1 to 0.
- R3: While running, a completion report without failure that is marked as the frame's last descriptor produces a one-cycle status write on the next edge. The write address is the index in use and the data is {1'b0, status}. A completion report that is not the last one produces no write.
- R4: While running, a completion report with failure produces a one-cycle status write on the next edge to the index in use, with data {1'b1, status}. The top bit makes the written value non-zero, whether or not the descriptor is the frame's last.
- R5: A failure sets the halt flag on the next edge and leaves the current index unchanged. It also loads the failing index into the error pointer.
- R6: A failure sets the error interrupt bit. The bit stays set until a register write with select 1 and data bit 0 set clears it. If a failure and such a clear fall on the same cycle, the bit ends up set.
- R7: While halted, completion reports are ignored: no status write occurs and the current index does not change.
- R8: While halted, only a 0-to-1 transition of the clear input between two consecutive sampled cycles ends the halt. The transition loads the current index from the recovery pointer on the next edge. Holding the clear input high has no further effect.
- R9: A register write with select 0 loads data bits 7:0 into the recovery pointer only when the value is below NUM_BD. Otherwise the write is ignored. The recovery pointer is visible on its own output.
- R10: While running, a rising edge on the clear input changes neither the halt flag nor the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bd_done_i | input | 1 | One-cycle report that the current descriptor has completed |
| bd_last_i | input | 1 | The completed descriptor is the last one of its frame |
| bd_fail_i | input | 1 | The frame was aborted or ended in error |
| bd_status_i | input | SW | Completion status from the transmit path |
| clr_tx_i | input | 1 | Clear-control level; a rising edge releases a halt |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 recovery pointer, 1 interrupt status |
| reg_wdata_i | input | 8 | Register write data |
| sts_we_o | output | 1 | Descriptor status write strobe |
| sts_addr_o | output | 8 | Descriptor address for the status write |
| sts_data_o | output | SW+1 | Status write data, failure flag in the top bit |
| txerr_o | output | 1 | Sticky transmit-error interrupt bit |
| err_ptr_o | output | 8 | Address of the last failing descriptor |
| rec_ptr_o | output | 8 | Recovery (restart) pointer |
| cur_ptr_o | output | 8 | Index of the descriptor in use |
| halted_o | output | 1 | Processing is frozen after a failure |

## Verification
The assertions take for granted that completion reports are well-formed single-cycle strobes. They also assume that bd_fail_i and bd_last_i are only meaningful together with bd_done_i, and that the clear input is a plain level whose previous value is taken from the cycle just before. Under those assumptions, the release check looks exactly two samples back, because a halt cannot begin sooner than two cycles after reset.

The stimulus drives every input on the falling clock edge. It issues at most one completion report per cycle and keeps failures rare, so that long runs of advances cross the wrap point. It also toggles the clear input and writes recovery values from both the legal and the out-of-range halves of the 8-bit space.

// File: rtl/txh_pkg.sv
package txh_pkg;
  // register select values
  localparam logic SEL_RECOV = 1'b0;
  localparam logic SEL_IRQ   = 1'b1;
  // pointer width: descriptor RAM addresses are 8 bits
  localparam int PW = 8;

  typedef enum logic {ST_RUN = 1'b0, ST_HALT = 1'b1} txh_state_e;
endpackage

// File: rtl/txh_rise.sv
module txh_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/txh_curptr.sv
module txh_curptr #(
  parameter int NUM_BD = 64,
  parameter int PW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  input  logic          load_i,
  input  logic [PW-1:0] load_val_i,
  output logic [PW-1:0] cur_o
);
  localparam logic [PW-1:0] LAST = PW'(NUM_BD - 1);

  logic [PW-1:0] cur_q;
  logic [PW-1:0] nxt;

  always_comb begin
    nxt = (cur_q == LAST) ? '0 : cur_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         cur_q <= '0;
    else if (load_i) cur_q <= load_val_i;
    else if (adv_i)  cur_q <= nxt;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/txh_regs.sv
module txh_regs #(
  parameter int NUM_BD = 64,
  parameter int PW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [7:0]    wdata_i,
  input  logic          err_set_i,
  input  logic [PW-1:0] err_addr_i,
  output logic [PW-1:0] rec_ptr_o,
  output logic [PW-1:0] err_ptr_o,
  output logic          txerr_o
);
  import txh_pkg::*;

  logic [PW-1:0] rec_q, err_q;
  logic          irq_q;
  logic          rec_ok;
  logic          irq_clr;

  assign rec_ok  = we_i && (sel_i == SEL_RECOV) && (int'(wdata_i) < NUM_BD);
  assign irq_clr = we_i && (sel_i == SEL_IRQ) && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q <= '0;
      err_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (rec_ok)         rec_q <= PW'(wdata_i);
      if (err_set_i)      err_q <= err_addr_i;
      if (err_set_i)      irq_q <= 1'b1;
      else if (irq_clr)   irq_q <= 1'b0;
    end
  end

  assign rec_ptr_o = rec_q;
  assign err_ptr_o = err_q;
  assign txerr_o   = irq_q;
endmodule

// File: rtl/txh_ctrl.sv
module txh_ctrl #(
  parameter int NUM_BD = 64,
  parameter int SW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bd_done_i,
  input  logic          bd_last_i,
  input  logic          bd_fail_i,
  input  logic [SW-1:0] bd_status_i,
  input  logic          clr_tx_i,
  input  logic          reg_we_i,
  input  logic          reg_sel_i,
  input  logic [7:0]    reg_wdata_i,
  output logic          sts_we_o,
  output logic [7:0]    sts_addr_o,
  output logic [SW:0]   sts_data_o,
  output logic          txerr_o,
  output logic [7:0]    err_ptr_o,
  output logic [7:0]    rec_ptr_o,
  output logic [7:0]    cur_ptr_o,
  output logic          halted_o
);
  import txh_pkg::*;

  txh_state_e    st_q, st_d;
  logic          clr_rise;
  logic          run_done, fail_ev, ok_ev, release_ev;
  logic [PW-1:0] cur;
  logic [PW-1:0] rec;

  txh_rise u_rise (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (clr_tx_i),
    .rise_o(clr_rise)
  );

  assign run_done   = (st_q == ST_RUN) && bd_done_i;
  assign fail_ev    = run_done && bd_fail_i;
  assign ok_ev      = run_done && !bd_fail_i;
  assign release_ev = (st_q == ST_HALT) && clr_rise;

  txh_curptr #(.NUM_BD(NUM_BD), .PW(PW)) u_cur (
    .clk       (clk),
    .rst       (rst),
    .adv_i     (ok_ev),
    .load_i    (release_ev),
    .load_val_i(rec),
    .cur_o     (cur)
  );

  txh_regs #(.NUM_BD(NUM_BD), .PW(PW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .err_set_i (fail_ev),
    .err_addr_i(cur),
    .rec_ptr_o (rec),
    .err_ptr_o (err_ptr_o),
    .txerr_o   (txerr_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (fail_ev)    st_d = ST_HALT;
      ST_HALT: if (release_ev) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_RUN;
    else     st_q <= st_d;
  end

  // registered descriptor status write port
  always_ff @(posedge clk) begin
    if (rst) begin
      sts_we_o   <= 1'b0;
      sts_addr_o <= '0;
      sts_data_o <= '0;
    end else begin
      sts_we_o <= fail_ev || (ok_ev && bd_last_i);
      if (run_done) begin
        sts_addr_o <= cur;
        sts_data_o <= {bd_fail_i, bd_status_i};
      end
    end
  end

  assign halted_o  = (st_q == ST_HALT);
  assign cur_ptr_o = cur;
  assign rec_ptr_o = rec;
endmodule

// File: rtl/txh_ctrl_chk.sv
module txh_ctrl_chk #(
  parameter int NUM_BD = 64,
  parameter int SW     = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        bd_done_i,
  input logic        bd_fail_i,
  input logic        clr_tx_i,
  input logic        sts_we_o,
  input logic [7:0]  sts_addr_o,
  input logic [SW:0] sts_data_o,
  input logic        txerr_o,
  input logic [7:0]  err_ptr_o,
  input logic [7:0]  rec_ptr_o,
  input logic [7:0]  cur_ptr_o,
  input logic        halted_o
);
  localparam logic [7:0] LAST = 8'(NUM_BD - 1);

  a_r7_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> !sts_we_o);

  a_r7_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
    (halted_o && !clr_tx_i) |=> $stable(cur_ptr_o));

  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    $rose(halted_o) |-> (err_ptr_o == $past(cur_ptr_o)) && $stable(cur_ptr_o));

  a_r6_irq_on_fail: assert property (@(posedge clk) disable iff (rst)
    $rose(halted_o) |-> txerr_o);

  a_r4_fail_write: assert property (@(posedge clk) disable iff (rst)
    $rose(halted_o) |-> sts_we_o && sts_data_o[SW] && (sts_addr_o == err_ptr_o));

  a_r8_release_edge: assert property (@(posedge clk) disable iff (rst)
    $fell(halted_o) |-> $past(clr_tx_i) && !$past(clr_tx_i, 2)
                        && (cur_ptr_o == $past(rec_ptr_o)));

  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (!halted_o && bd_done_i && !bd_fail_i) |=>
      (cur_ptr_o == (($past(cur_ptr_o) == LAST) ? 8'd0 : $past(cur_ptr_o) + 8'd1)));

  a_r9_rec_range: assert property (@(posedge clk) disable iff (rst)
    int'(rec_ptr_o) < NUM_BD);
endmodule

bind txh_ctrl txh_ctrl_chk #(.NUM_BD(NUM_BD), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bd_done_i (bd_done_i),
  .bd_fail_i (bd_fail_i),
  .clr_tx_i  (clr_tx_i),
  .sts_we_o  (sts_we_o),
  .sts_addr_o(sts_addr_o),
  .sts_data_o(sts_data_o),
  .txerr_o   (txerr_o),
  .err_ptr_o (err_ptr_o),
  .rec_ptr_o (rec_ptr_o),
  .cur_ptr_o (cur_ptr_o),
  .halted_o  (halted_o)
);

// File: tb/sim_txh_ctrl.sv
`timescale 1ns/1ps
module sim_txh_ctrl;
  localparam int NUM_BD = 64;
  localparam int SW     = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bd_done_i = 0, bd_last_i = 0, bd_fail_i = 0;
  logic [SW-1:0] bd_status_i = '0;
  logic          clr_tx_i = 0;
  logic          reg_we_i = 0, reg_sel_i = 0;
  logic [7:0]    reg_wdata_i = '0;
  logic          sts_we_o;
  logic [7:0]    sts_addr_o;
  logic [SW:0]   sts_data_o;
  logic          txerr_o;
  logic [7:0]    err_ptr_o, rec_ptr_o, cur_ptr_o;
  logic          halted_o;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [7:0]  m_cur, m_err, m_rec;
  logic        m_halt, m_irq, m_clrq, m_we;
  logic [7:0]  m_waddr;
  logic [SW:0] m_wdata;

  always #2 clk = ~clk;

  txh_ctrl #(.NUM_BD(NUM_BD), .SW(SW)) u0 (.*);

  function automatic logic [7:0] wrap_inc(input logic [7:0] v);
    return (int'(v) == NUM_BD - 1) ? 8'd0 : v + 8'd1;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cur = 0; m_err = 0; m_rec = 0; m_halt = 0; m_irq = 0; m_clrq = 0; m_we = 0;
    m_waddr = 0; m_wdata = 0;
  endtask

  // apply the inputs of the cycle just clocked to the model
  task automatic model_step();
    logic edge_c, fail_c;
    edge_c = clr_tx_i && !m_clrq;
    m_clrq = clr_tx_i;
    m_we   = 0;
    fail_c = 0;
    if (m_halt) begin
      if (edge_c) begin m_halt = 0; m_cur = m_rec; end
    end else if (bd_done_i) begin
      if (bd_fail_i) begin
        m_we = 1; m_waddr = m_cur; m_wdata = {1'b1, bd_status_i};
        m_halt = 1; m_err = m_cur; fail_c = 1;
      end else begin
        if (bd_last_i) begin m_we = 1; m_waddr = m_cur; m_wdata = {1'b0, bd_status_i}; end
        m_cur = wrap_inc(m_cur);
      end
    end
    if (fail_c) m_irq = 1;
    else if (reg_we_i && reg_sel_i && reg_wdata_i[0]) m_irq = 0;
    if (reg_we_i && !reg_sel_i && int'(reg_wdata_i) < NUM_BD) m_rec = reg_wdata_i;
  endtask

  task automatic compare_all();
    chk("R2 R7 cur", 16'(cur_ptr_o), 16'(m_cur));
    chk("R5 R8 halt", 16'(halted_o), 16'(m_halt));
    chk("R6 irq", 16'(txerr_o), 16'(m_irq));
    chk("R5 errptr", 16'(err_ptr_o), 16'(m_err));
    chk("R9 recptr", 16'(rec_ptr_o), 16'(m_rec));
    chk("R3 R4 R7 we", 16'(sts_we_o), 16'(m_we));
    if (m_we) begin
      chk("R3 R4 addr", 16'(sts_addr_o), 16'(m_waddr));
      chk("R3 R4 data", 16'(sts_data_o), 16'(m_wdata));
    end
  endtask

  task automatic step(input logic dn, input logic ls, input logic fl, input logic [SW-1:0] st,
                      input logic cl, input logic we, input logic sel, input logic [7:0] wd);
    @(negedge clk);
    bd_done_i = dn; bd_last_i = ls; bd_fail_i = fl; bd_status_i = st;
    clr_tx_i = cl; reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd;
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  task automatic idle(input logic cl);
    step(0, 0, 0, '0, cl, 0, 0, 8'h00);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: reset state
    chk("R1 cur", 16'(cur_ptr_o), 0);
    chk("R1 halt", 16'(halted_o), 0);
    chk("R1 irq", 16'(txerr_o), 0);
    chk("R1 err", 16'(err_ptr_o), 0);
    chk("R1 rec", 16'(rec_ptr_o), 0);
    chk("R1 we", 16'(sts_we_o), 0);

    // R10: clear edge while running does nothing
    idle(1); idle(0);
    // R2 wrap: advance through the whole ring and past it
    for (int i = 0; i < NUM_BD + 3; i++) step(1, (i % 4) == 3, 0, 8'(i + 1), 0, 0, 0, 0);
    chk("R2 wrap", 16'(cur_ptr_o), 16'(3));

    // R4 R5: failure on a non-last descriptor, clear asserted already (held high)
    step(1, 0, 1, 8'h00, 1, 0, 0, 0);
    chk("R4 flag nonzero", 16'(sts_data_o), 16'h100);
    // R7: reports ignored while halted; R8 holding clear high is no edge
    for (int i = 0; i < 4; i++) step(1, 1, 0, 8'h55, 1, 0, 0, 0);
    chk("R8 held high", 16'(halted_o), 1);
    // R9: out-of-range recovery write ignored, valid one accepted
    step(0, 0, 0, '0, 1, 1, 0, 8'(NUM_BD));
    step(0, 0, 0, '0, 1, 1, 0, 8'hff);
    step(0, 0, 0, '0, 1, 1, 0, 8'(NUM_BD - 1));
    // R6: failure and clear together keeps the bit; later clear works
    idle(0); idle(1);
    chk("R8 restart", 16'(cur_ptr_o), 16'(NUM_BD - 1));
    step(1, 1, 1, 8'h3c, 0, 1, 1, 8'h01);
    chk("R6 set wins", 16'(txerr_o), 1);
    idle(1);
    step(0, 0, 0, '0, 0, 1, 1, 8'h01);
    chk("R6 w1c", 16'(txerr_o), 0);

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      logic dn, ls, fl, cl, we, sel;
      logic [7:0] wd;
      dn  = ($urandom % 2) == 0;
      ls  = ($urandom % 3) == 0;
      fl  = ($urandom % 20) == 0;
      cl  = ($urandom % 4) == 0 ? ~clr_tx_i : clr_tx_i;
      we  = ($urandom % 8) == 0;
      sel = $urandom % 2;
      wd  = ($urandom % 2) ? 8'($urandom % NUM_BD) : 8'($urandom);
      step(dn, ls, fl, 8'($urandom), cl, we, sel, wd);
    end
    finish_run();
  end

  initial void'($urandom(32'd20240611));
endmodule